// File: doc/BRIEF.md
# Secure-Filtered GPIO Register Port

This block is a 16-pin general-purpose I/O controller with a small memory-mapped register interface, intended to be driven by a simple bus master such as a DMA engine that moves words between memory and the port. Software or the DMA chooses a direction for each pin, drives output values and samples pin inputs. Output bits can be changed with a plain read-modify-write. They can also be changed atomically through a combined set/clear register or through a clear-only register.

Each bus access carries a secure attribute. A 16-bit mask from outside the block marks pins as secure. A nonsecure access never sees or changes a secure pin's bits: those bits read as zero and writes to them are dropped without any error. Bits of nonsecure pins in the same access are handled normally. Secure accesses reach every bit.

The bus presents a byte offset, 32-bit write data, four byte strobes, a read/write flag and the secure flag, qualified by a select. Read data is registered and appears one cycle after the read request.

Top module: `lpio_port`

## Requirements
- R1: After reset, the mode and output registers are zero, so every `pin_oe` and `pin_out` bit is 0 and reads of offsets 0x00 and 0x14 return 0.
- R2: The register at offset 0x00 holds one direction bit per pin in bits 15:0, with 1 = output and 0 = input. `pin_oe[y]` equals that bit, so a pin in input mode has its output enable low.
- R3: The output register at offset 0x14 (bits 15:0) is readable and writable at all times and drives `pin_out`. A write changes only the bytes whose strobe is 1 (strobe bit b covers data bits 8b+7:8b).
- R4: A write to offset 0x18 sets output bit y for each 1 in data bit y (y = 0..15) and clears output bit y for each 1 in data bit 16+y. Zero bits and unstrobed bytes leave the output unchanged.
- R5: If one write to offset 0x18 has both data bit y and data bit 16+y at 1, output bit y ends at 1.
- R6: A write to offset 0x28 clears output bit y for each 1 in data bit y (bits 15:0). Data bits 31:16 of that write have no effect.
- R7: Reads of offsets 0x18 and 0x28 return 0. Offset 0x10 is read-only: writing it changes nothing.
- R8: Reads of offset 0x10 return `pin_in` after a two-flop synchronizer. A pin change is visible to a read issued two or more cycles after the change, and not to a read issued in the next cycle.
- R9: On a nonsecure write (`bus_secure` = 0), mode and output bits of pins with `pin_secure[y]` = 1 stay unchanged. Bits of other pins in the same write are updated.
- R10: On a nonsecure read, bits of secure pins read as 0 and the other bits read normally. A secure read returns all bits.
- R11: Reads of any offset other than 0x00, 0x10, 0x14, 0x18 and 0x28 return 0, and writes to them change nothing. Read bits 31:16 are always 0. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for writes |
| bus_secure | input | 1 | 1 = secure access |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_secure | input | 16 | Per-pin secure marking |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |

## Verification
A write takes effect at the clock edge that samples it, so `pin_out` and `pin_oe` are checked half a cycle after that edge. Read data is registered and is compared half a cycle after the edge that follows the request. The input path adds two synchronizer stages, so the bench holds a new `pin_in` value for at least three cycles before any read it checks against. The bench also issues one directed read in the cycle right after a pin change and expects the old value. Random writes, reads, strobes and security masks are compared against a bench model that uses the same timing.

// File: rtl/lpio_pkg.sv
// Package: shared constants and register-select type for the GPIO port.
// Assumes byte offsets on a 6-bit address; bits 1:0 are ignored by decode.
package lpio_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int HALF_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PINS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_SETCL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h28;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_PINS,
        SEL_OUT,
        SEL_SETCL,
        SEL_CLR
    } reg_sel_e;
endpackage

// File: rtl/lpio_sync.sv
// Module: two-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module lpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pin values through two flops, clearing both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/lpio_access_dec.sv
// Module: decodes one bus access into per-register bit masks.
// Applies byte strobes and the per-pin security filter, so downstream
// registers only see bits that this access may legally touch.
// Assumes PINS <= 16 and the fixed layout of the set/clear register.
module lpio_access_dec
    import lpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    input  logic              secure,
    input  logic [PINS-1:0]   pin_secure,
    output reg_sel_e          reg_sel,
    output logic              rd_en,
    output logic [PINS-1:0]   rd_mask,
    output logic [PINS-1:0]   dir_wmask,
    output logic [PINS-1:0]   out_wmask,
    output logic [PINS-1:0]   wr_bits,
    output logic [PINS-1:0]   set_bits,
    output logic [PINS-1:0]   clr_bits
);
    logic [DATA_W-1:0] byte_mask;
    logic [PINS-1:0]   sec_ok;
    logic [PINS-1:0]   lo_mask;
    logic [PINS-1:0]   hi_mask;
    logic              wr_act;

    // Expand each byte strobe into eight data-bit enables.
    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
        assign byte_mask[8*b +: 8] = {8{strb[b]}};
    end

    // Select the addressed register from the word part of the offset.
    always_comb begin
        unique case (addr[ADDR_W-1:2])
            OFS_DIR[ADDR_W-1:2]:   reg_sel = SEL_DIR;
            OFS_PINS[ADDR_W-1:2]:  reg_sel = SEL_PINS;
            OFS_OUT[ADDR_W-1:2]:   reg_sel = SEL_OUT;
            OFS_SETCL[ADDR_W-1:2]: reg_sel = SEL_SETCL;
            OFS_CLR[ADDR_W-1:2]:   reg_sel = SEL_CLR;
            default:               reg_sel = SEL_NONE;
        endcase
    end

    assign sec_ok  = secure ? {PINS{1'b1}} : ~pin_secure;
    assign lo_mask = byte_mask[PINS-1:0] & sec_ok;
    assign hi_mask = byte_mask[HALF_W +: PINS] & sec_ok;
    assign wr_act  = sel && wr;
    assign rd_en   = sel && !wr;
    assign rd_mask = sec_ok;
    assign wr_bits = wdata[PINS-1:0];

    // Build the per-register write, set and clear masks for this access.
    always_comb begin
        dir_wmask = '0;
        out_wmask = '0;
        set_bits  = '0;
        clr_bits  = '0;
        if (wr_act) begin
            unique case (reg_sel)
                SEL_DIR:   dir_wmask = lo_mask;
                SEL_OUT:   out_wmask = lo_mask;
                SEL_SETCL: begin
                    set_bits = wdata[PINS-1:0] & lo_mask;
                    clr_bits = wdata[HALF_W +: PINS] & hi_mask;
                end
                SEL_CLR:   clr_bits = wdata[PINS-1:0] & lo_mask;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/lpio_regs.sv
// Module: direction and output-value storage for the pins.
// Assumes masks arrive already filtered for strobes and security; a set
// overrides a clear on the same bit.
module lpio_regs #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] dir_wmask,
    input  logic [PINS-1:0] out_wmask,
    input  logic [PINS-1:0] wr_bits,
    input  logic [PINS-1:0] set_bits,
    input  logic [PINS-1:0] clr_bits,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q
);
    logic [PINS-1:0] out_direct;
    logic [PINS-1:0] out_next;

    // Merge direct write, then clear, then set (set has the last word).
    always_comb begin
        out_direct = (out_q & ~out_wmask) | (wr_bits & out_wmask);
        out_next   = (out_direct & ~clr_bits) | set_bits;
    end

    // Hold direction and output values, clearing them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            dir_q <= (dir_q & ~dir_wmask) | (wr_bits & dir_wmask);
            out_q <= out_next;
        end
    end

    // A requested set is visible at the next cycle even if a clear collides.
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((out_q & $past(set_bits)) == $past(set_bits)));

    // A clear not overridden by a set leaves the bit low.
    assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & ~set_bits) != '0) |=> ((out_q & $past(clr_bits & ~set_bits)) == '0));
endmodule

// File: rtl/lpio_port.sv
// Module: top of the secure-filtered GPIO port.
// Joins the access decoder, the register store and the input synchronizer,
// and registers read data for one-cycle read latency.
// Assumes PINS <= 16; reserved bits and offsets read as zero.
module lpio_port
    import lpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [STRB_W-1:0] bus_strb,
    input  logic              bus_secure,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_secure,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out
);
    localparam int PAD_W = DATA_W - PINS;

    reg_sel_e          reg_sel;
    logic              rd_en;
    logic [PINS-1:0]   rd_mask;
    logic [PINS-1:0]   dir_wmask;
    logic [PINS-1:0]   out_wmask;
    logic [PINS-1:0]   wr_bits;
    logic [PINS-1:0]   set_bits;
    logic [PINS-1:0]   clr_bits;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   out_q;
    logic [PINS-1:0]   pins_sync;
    logic [PINS-1:0]   rd_value;
    logic [DATA_W-1:0] rdata_q;

    lpio_access_dec #(.PINS(PINS)) u_dec (
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .strb       (bus_strb),
        .secure     (bus_secure),
        .pin_secure (pin_secure),
        .reg_sel    (reg_sel),
        .rd_en      (rd_en),
        .rd_mask    (rd_mask),
        .dir_wmask  (dir_wmask),
        .out_wmask  (out_wmask),
        .wr_bits    (wr_bits),
        .set_bits   (set_bits),
        .clr_bits   (clr_bits)
    );

    lpio_regs #(.PINS(PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_wmask (dir_wmask),
        .out_wmask (out_wmask),
        .wr_bits   (wr_bits),
        .set_bits  (set_bits),
        .clr_bits  (clr_bits),
        .dir_q     (dir_q),
        .out_q     (out_q)
    );

    lpio_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pins_sync)
    );

    // Choose the readable value of the addressed register, security-masked.
    always_comb begin
        unique case (reg_sel)
            SEL_DIR:  rd_value = dir_q & rd_mask;
            SEL_PINS: rd_value = pins_sync & rd_mask;
            SEL_OUT:  rd_value = out_q & rd_mask;
            default:  rd_value = '0;
        endcase
    end

    // Register read data; it is zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= {{PAD_W{1'b0}}, rd_value};
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_oe    = dir_q;
    assign pin_out   = out_q;

    // Nonsecure writes leave every secure pin's direction and value alone.
    assert_ns_write_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_secure) |=>
        ((((pin_out ^ $past(pin_out)) | (pin_oe ^ $past(pin_oe))) & $past(pin_secure)) == '0));

    // Nonsecure reads return zero in every secure pin's bit.
    assert_ns_read_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_secure) |=> ((bus_rdata[PINS-1:0] & $past(pin_secure)) == '0));

    // Write-only registers read back as zero.
    assert_wo_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (reg_sel == SEL_SETCL || reg_sel == SEL_CLR)) |=> (bus_rdata == '0));

    // Reserved offsets read zero and writes to them change no pin state.
    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && reg_sel == SEL_NONE) |=> (bus_rdata == '0 && $stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/lpio_port_bench.sv
module lpio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic        bus_secure = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_secure = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_dir = '0;
    logic [15:0] m_out = '0;

    always #4 clk = ~clk;

    lpio_port u_lpio_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_secure(bus_secure), .bus_rdata(bus_rdata), .pin_secure(pin_secure),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] s);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{s[b]}};
        return m;
    endfunction

    // Model update for a write, from the requirements.
    task automatic model_write(input logic [5:0] a, input logic [31:0] d,
                               input logic [3:0] s, input logic sec);
        logic [31:0] bm = bmask(s);
        logic [15:0] ok = sec ? 16'hFFFF : ~pin_secure;
        logic [15:0] lo = bm[15:0] & ok;
        logic [15:0] hi = bm[31:16] & ok;
        case ({a[5:2], 2'b00})
            6'h00: m_dir = (m_dir & ~lo) | (d[15:0] & lo);
            6'h14: m_out = (m_out & ~lo) | (d[15:0] & lo);
            6'h18: m_out = (m_out & ~(d[31:16] & hi)) | (d[15:0] & lo);
            6'h28: m_out = m_out & ~(d[15:0] & lo);
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] a, input logic sec);
        logic [15:0] ok = sec ? 16'hFFFF : ~pin_secure;
        case ({a[5:2], 2'b00})
            6'h00: return {16'h0, m_dir & ok};
            6'h10: return {16'h0, pin_in & ok};
            6'h14: return {16'h0, m_out & ok};
            default: return 32'h0;
        endcase
    endfunction

    task automatic access(input logic wr, input logic [5:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic sec, output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        bus_strb = s; bus_secure = sec;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata;
    endtask

    task automatic wr_reg(input string req, input logic [5:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic sec);
        logic [31:0] unused;
        model_write(a, d, s, sec);
        access(1'b1, a, d, s, sec, unused);
        chk(req, {16'h0, pin_out}, {16'h0, m_out});
        chk(req, {16'h0, pin_oe}, {16'h0, m_dir});
    endtask

    task automatic rd_reg(input string req, input logic [5:0] a, input logic sec);
        logic [31:0] got;
        logic [31:0] exp = model_read(a, sec);
        access(1'b0, a, 32'h0, 4'h0, sec, got);
        chk(req, got, exp);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", {16'h0, pin_oe}, 32'h0);
        chk("R1", {16'h0, pin_out}, 32'h0);
        rd_reg("R1", 6'h00, 1'b1);
        rd_reg("R1", 6'h14, 1'b1);

        // R2: direction bits drive output enables
        wr_reg("R2", 6'h00, 32'h0000_A5C3, 4'hF, 1'b1);
        rd_reg("R2", 6'h00, 1'b1);

        // R3: byte-strobed direct output writes
        wr_reg("R3", 6'h14, 32'h0000_1234, 4'hF, 1'b1);
        wr_reg("R3", 6'h14, 32'hFFFF_FFFF, 4'b0001, 1'b1);
        chk("R3", {16'h0, pin_out}, 32'h0000_12FF);
        wr_reg("R3", 6'h14, 32'h0000_AB00, 4'b0010, 1'b1);
        rd_reg("R3", 6'h14, 1'b1);

        // R4: set and clear; zeros have no effect
        wr_reg("R4", 6'h18, 32'h00FF_0001, 4'hF, 1'b1);
        chk("R4", {16'h0, pin_out}, 32'h0000_AB01);
        wr_reg("R4", 6'h18, 32'h0000_0000, 4'hF, 1'b1);
        wr_reg("R4", 6'h18, 32'hFFFF_FFFF, 4'b0000, 1'b1);

        // R5: set wins on conflict
        wr_reg("R5", 6'h14, 32'h0000_0000, 4'hF, 1'b1);
        wr_reg("R5", 6'h18, 32'h8001_8001, 4'hF, 1'b1);
        chk("R5", {16'h0, pin_out}, 32'h0000_8001);

        // R6: clear-only register; upper half ignored
        wr_reg("R6", 6'h14, 32'h0000_FFFF, 4'hF, 1'b1);
        wr_reg("R6", 6'h28, 32'hFFFF_000F, 4'hF, 1'b1);
        chk("R6", {16'h0, pin_out}, 32'h0000_FFF0);

        // R7: write-only registers read zero; input register not writable
        rd_reg("R7", 6'h18, 1'b1);
        rd_reg("R7", 6'h28, 1'b1);
        wr_reg("R7", 6'h10, 32'hFFFF_FFFF, 4'hF, 1'b1);
        rd_reg("R7", 6'h10, 1'b1);

        // R8: synchronizer latency on the input register
        @(negedge clk);
        pin_in = 16'h3C5A;
        access(1'b0, 6'h10, 32'h0, 4'h0, 1'b1, got);
        chk("R8", got, 32'h0000_0000);
        access(1'b0, 6'h10, 32'h0, 4'h0, 1'b1, got);
        chk("R8", got, 32'h0000_3C5A);

        // R9 and R10: security filtering
        pin_secure = 16'hFF00;
        wr_reg("R9", 6'h14, 32'h0000_0000, 4'hF, 1'b0);
        chk("R9", {16'h0, pin_out}, 32'h0000_FF00);
        wr_reg("R9", 6'h18, 32'h00FF_FF00, 4'hF, 1'b0);
        wr_reg("R9", 6'h00, 32'h0000_0000, 4'hF, 1'b0);
        rd_reg("R10", 6'h14, 1'b0);
        rd_reg("R10", 6'h10, 1'b0);
        rd_reg("R10", 6'h14, 1'b1);

        // R11: reserved offsets and ignored low address bits
        wr_reg("R11", 6'h04, 32'hFFFF_FFFF, 4'hF, 1'b1);
        wr_reg("R11", 6'h20, 32'hFFFF_FFFF, 4'hF, 1'b1);
        rd_reg("R11", 6'h0C, 1'b1);
        rd_reg("R11", 6'h3C, 1'b1);
        wr_reg("R11", 6'h17, 32'h0000_5A5A, 4'hF, 1'b1);
        rd_reg("R11", 6'h15, 1'b1);

        // Random mix of accesses checked against the model
        for (int i = 0; i < 600; i++) begin
            logic [5:0] a = {4'($urandom % 16), 2'b00};
            if (i % 50 == 0) pin_secure = 16'($urandom);
            if (i % 40 == 0) set_pins(16'($urandom));
            if ($urandom % 2 == 0)
                wr_reg("R9", a, $urandom, 4'($urandom), 1'($urandom));
            else
                rd_reg("R10", a, 1'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule